// File: doc/BRIEF.md
# Binary64 to Signed 64-bit Truncating Converter

This unit turns the bit pattern of an IEEE-754 double-precision number into a two's-complement 64-bit integer. It always drops the fractional part, so it rounds toward zero. No rounding-mode input exists. Values outside the signed 64-bit range, infinities and NaNs produce fixed saturation or sentinel codes, and the matching invalid-operation flags are raised. Fractional inputs raise an inexact flag.

The unit sits in a floating-point pipeline. Each operand arrives with a one-cycle valid strobe, a record flag and the current sticky status word. One clock edge later the unit presents three things: the integer result, the status word with any new exceptions merged in, and a 4-bit condition field. The condition field is copied from the summary bits of the updated status when the record flag was set. Decode, trap delivery and register writeback belong to the surrounding pipeline.

Top module: `dbl2int_trunc`

## Requirements
- R1: An in-range finite input is converted by truncation toward zero in both signs (2.75 gives 2, -2.75 gives -2), and integer-valued inputs up to 2^63 - 2^10 convert exactly with no new flags.
- R2: Any NaN input (exponent all ones, fraction nonzero) gives 0x8000_0000_0000_0000 and sets the invalid-conversion, invalid-summary and exception-summary bits.
- R3: A signaling NaN (fraction MSB, bit 51, equal to 0) also sets the signaling-NaN bit; a quiet NaN (bit 51 set) does not.
- R4: A positive input at or above 2^63, including +infinity, gives 0x7FFF_FFFF_FFFF_FFFF and sets invalid-conversion, invalid-summary and exception-summary.
- R5: A negative input below -2^63, including -infinity, gives 0x8000_0000_0000_0000 with the same three flags as R4.
- R6: An input of exactly -2^63 gives 0x8000_0000_0000_0000 and raises no flag.
- R7: A finite in-range input with a nonzero fractional part sets the inexact and exception-summary bits.
- R8: Both zeros give 0 with no flag. A nonzero magnitude below 1, including subnormals, gives 0 and sets inexact and exception-summary.
- R9: Status bits are sticky. The 7-bit status word is laid out as bit 6 exception summary, bit 5 enabled-exception summary, bit 4 invalid summary, bit 3 overflow, bit 2 inexact, bit 1 invalid conversion and bit 0 signaling NaN. The output word is the input word ORed with the new flags, so no bit is ever cleared.
- R10: With the record flag at 1, the condition output is {status[6], status[5], status[4], status[3]} of the updated status word, with bit 3 holding the exception summary. With the record flag at 0 it is 0.
- R11: After reset every output is 0. The outputs update on the first clock edge that samples the valid strobe high, and the output valid pulses for that one cycle. Result, status and condition hold while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand strobe |
| opBits | input | 64 | binary64 operand bit pattern |
| recordEn | input | 1 | Request a condition-field update |
| statusIn | input | 7 | Current sticky status word (layout in R9) |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| resultOut | output | 64 | Signed 64-bit truncated integer |
| statusOut | output | 7 | Status word with new flags merged in |
| condOut | output | 4 | Condition field (R10) |

## Verification
Result, status and condition all come from one register stage, so each is due exactly one rising edge after the strobe is sampled. The bench drives each operand on a falling edge and holds the strobe across one rising edge. It then reads all three outputs on the following falling edge, where they are stable. Idle cycles with a changed operand follow some operations, and at the next falling edge the bench confirms that the outputs held and that the valid strobe dropped.

// File: rtl/d2i_pkg.sv
package d2i_pkg;
  localparam int DBL_W   = 64;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int INT_W   = 64;
  localparam int SHIFT_W = $clog2(INT_W);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int STAT_W  = 7;
  localparam int COND_W  = 4;

  // Status word bit positions; the condition field depends on the top four.
  localparam int ST_EXC  = 6;
  localparam int ST_EN   = 5;
  localparam int ST_INV  = 4;
  localparam int ST_OVF  = 3;
  localparam int ST_INX  = 2;
  localparam int ST_CVT  = 1;
  localparam int ST_SNAN = 0;

  typedef struct packed {
    logic               load;
    logic               selNegSent;
    logic               selPosSat;
    logic               selZero;
    logic [SHIFT_W-1:0] shiftAmt;
  } d2i_strobe_t;
endpackage

// File: rtl/d2i_datapath.sv
module d2i_datapath
  import d2i_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DBL_W-1:0]  opBits,
  input  d2i_strobe_t       strobe,
  output logic              lostBits,
  output logic [INT_W-1:0]  resultOut
);
  localparam int WIDE_W = INT_W + FRAC_W;
  localparam logic [INT_W-1:0] NEG_SENT = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] POS_SAT  = ~NEG_SENT;

  logic [WIDE_W-1:0] wideVal;
  logic [INT_W-1:0]  magnitude;
  logic [INT_W-1:0]  signedVal;
  logic [INT_W-1:0]  nextResult;

  // Hidden one plus fraction, shifted left by the unbiased exponent:
  // integer part lands in the top INT_W bits, discarded bits below.
  always_comb begin
    wideVal   = {{(INT_W-1){1'b0}}, 1'b1, opBits[FRAC_W-1:0]} << strobe.shiftAmt;
    magnitude = wideVal[WIDE_W-1:FRAC_W];
    lostBits  = |wideVal[FRAC_W-1:0];
    signedVal = opBits[DBL_W-1] ? (INT_W'(0) - magnitude) : magnitude;
  end

  always_comb begin
    if (strobe.selNegSent)     nextResult = NEG_SENT;
    else if (strobe.selPosSat) nextResult = POS_SAT;
    else if (strobe.selZero)   nextResult = '0;
    else                       nextResult = signedVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            resultOut <= '0;
    else if (strobe.load) resultOut <= nextResult;
  end

  // R2 R5 R6: negative sentinel selection reaches the result register
  assert_neg_sentinel_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.load && strobe.selNegSent) |-> resultOut == NEG_SENT);

  assert_pos_saturate_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.load && strobe.selPosSat) |-> resultOut == POS_SAT);

  assert_zero_small_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.load && strobe.selZero) |-> resultOut == '0);

  assert_one_select_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.selNegSent, strobe.selPosSat, strobe.selZero}));

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.load) && $past(rstN) |-> $stable(resultOut));
endmodule

// File: rtl/d2i_control.sv
module d2i_control
  import d2i_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DBL_W-1:0]  opBits,
  input  logic              recordEn,
  input  logic [STAT_W-1:0] statusIn,
  input  logic              lostBits,
  output d2i_strobe_t       strobe,
  output logic              outValid,
  output logic [STAT_W-1:0] statusOut,
  output logic [COND_W-1:0] condOut
);
  localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_SAT  = EXP_W'(BIAS + INT_W - 1);
  localparam logic [EXP_W-1:0] EXP_MAX  = '1;

  logic              signBit;
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic isNan, isSnan, bigMag, exactMin, posSat, negSat, smallMag, midMag;
  logic newCvt, newSnan, newInx;
  logic [STAT_W-1:0] nextStatus;
  logic [COND_W-1:0] nextCond;

  always_comb begin
    signBit   = opBits[DBL_W-1];
    expField  = opBits[DBL_W-2 -: EXP_W];
    fracField = opBits[FRAC_W-1:0];

    isNan    = (expField == EXP_MAX) && (fracField != '0);
    isSnan   = isNan && !fracField[FRAC_W-1];
    bigMag   = expField >= EXP_SAT;
    exactMin = signBit && (expField == EXP_SAT) && (fracField == '0);
    posSat   = !isNan && !signBit && bigMag;
    negSat   = !isNan && signBit && bigMag && !exactMin;
    smallMag = expField < EXP_ONE;
    midMag   = !bigMag && !smallMag;

    strobe.load       = inValid;
    strobe.selNegSent = isNan || negSat || exactMin;
    strobe.selPosSat  = posSat;
    strobe.selZero    = smallMag;
    strobe.shiftAmt   = midMag ? SHIFT_W'(expField - EXP_ONE) : '0;

    newCvt  = isNan || posSat || negSat;
    newSnan = isSnan;
    newInx  = (smallMag && (opBits[DBL_W-2:0] != '0)) || (midMag && lostBits);

    nextStatus          = statusIn;
    nextStatus[ST_CVT]  = statusIn[ST_CVT]  | newCvt;
    nextStatus[ST_SNAN] = statusIn[ST_SNAN] | newSnan;
    nextStatus[ST_INX]  = statusIn[ST_INX]  | newInx;
    nextStatus[ST_INV]  = statusIn[ST_INV]  | newCvt | newSnan;
    nextStatus[ST_EXC]  = statusIn[ST_EXC]  | newCvt | newSnan | newInx;

    nextCond = recordEn ? {nextStatus[ST_EXC], nextStatus[ST_EN],
                           nextStatus[ST_INV], nextStatus[ST_OVF]} : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      statusOut <= '0;
      condOut   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        statusOut <= nextStatus;
        condOut   <= nextCond;
      end
    end
  end

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (statusOut & $past(statusIn)) == $past(statusIn));

  assert_cond_map_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(recordEn) |->
      condOut == {statusOut[ST_EXC], statusOut[ST_EN], statusOut[ST_INV], statusOut[ST_OVF]});

  assert_cond_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !$past(recordEn) |-> condOut == '0);

  assert_snan_has_cvt_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid && statusOut[ST_SNAN] && !$past(statusIn[ST_SNAN]) |-> statusOut[ST_CVT]);

  assert_inexact_summary_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && statusOut[ST_INX] && !$past(statusIn[ST_INX]) |-> statusOut[ST_EXC]);

  assert_invalid_summary_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && statusOut[ST_CVT] |-> statusOut[ST_INV] && statusOut[ST_EXC]);

  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));
endmodule

// File: rtl/dbl2int_trunc.sv
module dbl2int_trunc
  import d2i_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DBL_W-1:0]  opBits,
  input  logic              recordEn,
  input  logic [STAT_W-1:0] statusIn,
  output logic              outValid,
  output logic [INT_W-1:0]  resultOut,
  output logic [STAT_W-1:0] statusOut,
  output logic [COND_W-1:0] condOut
);
  d2i_strobe_t strobe;
  logic        lostBits;

  d2i_control i_control (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opBits(opBits),
    .recordEn(recordEn), .statusIn(statusIn), .lostBits(lostBits),
    .strobe(strobe), .outValid(outValid), .statusOut(statusOut), .condOut(condOut)
  );

  d2i_datapath i_datapath (
    .clk(clk), .rstN(rstN), .opBits(opBits), .strobe(strobe),
    .lostBits(lostBits), .resultOut(resultOut)
  );
endmodule

// File: tb/test_dbl2int_trunc.sv
module test_dbl2int_trunc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] opBits = '0;
  logic        recordEn = 1'b0;
  logic [6:0]  statusIn = '0;
  logic        outValid;
  logic [63:0] resultOut;
  logic [6:0]  statusOut;
  logic [3:0]  condOut;

  int total = 0;
  int failed = 0;

  always #4 clk = ~clk;

  dbl2int_trunc i_dbl2int_trunc (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opBits(opBits),
    .recordEn(recordEn), .statusIn(statusIn), .outValid(outValid),
    .resultOut(resultOut), .statusOut(statusOut), .condOut(condOut)
  );

  task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Drive on a falling edge, capture on the rising edge, read on the next falling edge.
  task automatic convert(input string req, input logic [63:0] op, input logic rec,
                         input logic [6:0] st, input logic [63:0] expRes,
                         input logic [6:0] expSt, input logic [3:0] expCond);
    opBits = op; recordEn = rec; statusIn = st; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(req, "valid", {63'b0, outValid}, 64'd1);
    check(req, "result", resultOut, expRes);
    check(req, "status", {57'b0, statusOut}, {57'b0, expSt});
    check(req, "cond", {60'b0, condOut}, {60'b0, expCond});
  endtask

  task automatic idle_hold(input string req, input logic [63:0] expRes, input logic [6:0] expSt);
    opBits = 64'h4024_0000_0000_0000; statusIn = 7'h7F; recordEn = 1'b1;
    @(negedge clk);
    check(req, "idle valid", {63'b0, outValid}, 64'd0);
    check(req, "idle result", resultOut, expRes);
    check(req, "idle status", {57'b0, statusOut}, {57'b0, expSt});
  endtask

  task automatic test_reset();
    check("R11", "reset valid", {63'b0, outValid}, 64'd0);
    check("R11", "reset result", resultOut, 64'd0);
    check("R11", "reset status", {57'b0, statusOut}, 64'd0);
    check("R11", "reset cond", {60'b0, condOut}, 64'd0);
  endtask

  task automatic test_truncation();
    convert("R1", 64'h4008_0000_0000_0000, 0, 0, 64'd3, 7'h00, 4'h0);
    convert("R1", 64'h3FF0_0000_0000_0000, 0, 0, 64'd1, 7'h00, 4'h0);
    convert("R1", 64'h4330_0000_0000_0001, 0, 0, 64'h0010_0000_0000_0001, 7'h00, 4'h0);
    convert("R1", 64'h43D0_0000_0000_0000, 0, 0, 64'h4000_0000_0000_0000, 7'h00, 4'h0);
    convert("R1", 64'h43DF_FFFF_FFFF_FFFF, 0, 0, 64'h7FFF_FFFF_FFFF_FC00, 7'h00, 4'h0);
    convert("R1", 64'hC059_0000_0000_0000, 0, 0, 64'hFFFF_FFFF_FFFF_FF9C, 7'h00, 4'h0);
  endtask

  task automatic test_inexact();
    convert("R7", 64'h4006_0000_0000_0000, 0, 0, 64'd2, 7'h44, 4'h0);
    convert("R7", 64'hC006_0000_0000_0000, 0, 0, 64'hFFFF_FFFF_FFFF_FFFE, 7'h44, 4'h0);
    convert("R7", 64'h4330_0000_0000_0000 - 64'd1, 0, 0, 64'h000F_FFFF_FFFF_FFFF, 7'h44, 4'h0);
  endtask

  task automatic test_nan();
    convert("R2", 64'h7FF8_0000_0000_0000, 0, 0, 64'h8000_0000_0000_0000, 7'h52, 4'h0);
    convert("R3", 64'h7FF0_0000_0000_0001, 0, 0, 64'h8000_0000_0000_0000, 7'h53, 4'h0);
    convert("R3", 64'hFFF4_0000_0000_0000, 0, 0, 64'h8000_0000_0000_0000, 7'h53, 4'h0);
  endtask

  task automatic test_range();
    convert("R4", 64'h43E0_0000_0000_0000, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 7'h52, 4'h0);
    convert("R4", 64'h7FF0_0000_0000_0000, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 7'h52, 4'h0);
    convert("R5", 64'hC3E0_0000_0000_0001, 0, 0, 64'h8000_0000_0000_0000, 7'h52, 4'h0);
    convert("R5", 64'hFFF0_0000_0000_0000, 0, 0, 64'h8000_0000_0000_0000, 7'h52, 4'h0);
    convert("R6", 64'hC3E0_0000_0000_0000, 0, 0, 64'h8000_0000_0000_0000, 7'h00, 4'h0);
  endtask

  task automatic test_small();
    convert("R8", 64'h0000_0000_0000_0000, 0, 0, 64'd0, 7'h00, 4'h0);
    convert("R8", 64'h8000_0000_0000_0000, 0, 0, 64'd0, 7'h00, 4'h0);
    convert("R8", 64'h0000_0000_0000_0001, 0, 0, 64'd0, 7'h44, 4'h0);
    convert("R8", 64'h800F_FFFF_FFFF_FFFF, 0, 0, 64'd0, 7'h44, 4'h0);
    convert("R8", 64'hBFE0_0000_0000_0000, 0, 0, 64'd0, 7'h44, 4'h0);
  endtask

  task automatic test_sticky();
    convert("R9", 64'h4008_0000_0000_0000, 0, 7'h7F, 64'd3, 7'h7F, 4'h0);
    convert("R9", 64'h4006_0000_0000_0000, 0, 7'h28, 64'd2, 7'h6C, 4'h0);
    convert("R9", 64'h7FF0_0000_0000_0001, 0, 7'h04, 64'h8000_0000_0000_0000, 7'h57, 4'h0);
  endtask

  task automatic test_record();
    convert("R10", 64'h43E0_0000_0000_0000, 1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 7'h52, 4'b1010);
    convert("R10", 64'h4008_0000_0000_0000, 1, 7'h28, 64'd3, 7'h28, 4'b0101);
    convert("R10", 64'h4006_0000_0000_0000, 1, 0, 64'd2, 7'h44, 4'b1000);
    convert("R10", 64'h43E0_0000_0000_0000, 0, 7'h28, 64'h7FFF_FFFF_FFFF_FFFF, 7'h7A, 4'b0000);
  endtask

  task automatic test_hold();
    convert("R11", 64'hC006_0000_0000_0000, 1, 0, 64'hFFFF_FFFF_FFFF_FFFE, 7'h44, 4'b1000);
    idle_hold("R11", 64'hFFFF_FFFF_FFFF_FFFE, 7'h44);
    check("R11", "idle cond", {60'b0, condOut}, 64'd8);
    idle_hold("R11", 64'hFFFF_FFFF_FFFF_FFFE, 7'h44);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_truncation();
    test_inexact();
    test_nan();
    test_range();
    test_small();
    test_sticky();
    test_record();
    test_hold();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule